// File: doc/BRIEF.md
# Interrupt Trigger-Mode and Latch-Clear Conditioner

This block sits between the raw legacy interrupt request pins and an interrupt controller. It handles the upper bank of eight request lines (IRQ8 to IRQ15) and the keyboard request (IRQ1). Each raw input first passes through a two-flop synchronizer. A line in edge mode then holds a pending latch that a synchronized rising edge sets. A line in level mode passes its synchronized input straight through.

A byte-wide trigger-mode register sits on a simple I/O bus with address, write data, read strobe, write strobe and read data. Software sets the mode of each line with one bit of that register. Two lines, IRQ8 and IRQ13, are hard-wired to edge mode, and their register bits are reserved. Edge latches on the ordinary lines are cleared by a per-line acknowledge input.

The keyboard latch on IRQ1 is cleared as a side effect of any processor read of the keyboard data port. When the pointing-device function is enabled, the IRQ12 latch is cleared the same way. The block only snoops that port and never drives read data for it.

Top module: `irq_trigger_cond`

## Requirements
- R1: The trigger-mode register is read and written at I/O address 0x4D1. It reads 0x00 after reset, so every line starts in edge mode. A read at that address raises `io_rdata_en` and returns the stored value on `io_rdata`.
- R2: Register bit i selects the mode of line IRQ(8+i), output `irq_hi_out[i]`. A value of 0 selects edge mode and 1 selects level mode. Writes to bits 1, 2, 3, 4, 6 and 7 are stored.
- R3: Register bits 0 and 5 ignore writes and always read 0. IRQ8 and IRQ13 (`irq_hi_out[0]` and `irq_hi_out[5]`) therefore always act in edge mode.
- R4: In edge mode, a rising raw input drives the output high on the third rising clock edge after the input change. The output then stays high after the raw input falls, until it is cleared.
- R5: In edge mode, a one-cycle pulse on `irq_ack[i]` clears the pending output of line i by the next clock edge. In level mode, `irq_ack[i]` has no effect on the output.
- R6: In level mode, the output equals the raw input delayed by two clock edges. The output falls when the input falls, without any acknowledge.
- R7: IRQ1 (`kbd_irq_in` to `kbd_irq_out`) is always edge-latched. It is cleared only by a read (`io_rd` = 1) of I/O address 0x60.
- R8: While `mouse_en` is 1, IRQ12 (`irq_hi_out[4]`) is edge-latched whatever register bit 4 holds. In that state `irq_ack[4]` is ignored and a read of 0x60 clears the latch. While `mouse_en` is 0, IRQ12 behaves like any other programmable line.
- R9: A read of 0x60 leaves `io_rdata_en` at 0 and `io_rdata` at 0x00. A write to 0x60 clears no latch.
- R10: When a read of 0x60 and a synchronized rising edge on IRQ1 or on mouse-mode IRQ12 fall in the same cycle, the latch stays set.
- R11: Accesses to any address other than 0x4D1 do not change the register and do not raise `io_rdata_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O bus address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_rdata | output | 8 | Read data, 0 when not driven |
| io_rdata_en | output | 1 | High when the block supplies read data |
| irq_hi_in | input | 8 | Raw IRQ8..IRQ15 request inputs, bit i is IRQ(8+i) |
| kbd_irq_in | input | 1 | Raw keyboard request (IRQ1) |
| mouse_en | input | 1 | Pointing-device function enable for IRQ12 |
| irq_ack | input | 8 | Per-line acknowledge for edge latches of IRQ8..IRQ15 |
| irq_hi_out | output | 8 | Conditioned IRQ8..IRQ15 outputs |
| kbd_irq_out | output | 1 | Conditioned keyboard request output |

## Verification
The assertions check several rules on every cycle. The register comes out of reset at zero. Reserved bits never read as 1. IRQ8 and IRQ13 rise only after a detected edge, and a pending edge output holds until it is acknowledged. A snooped read of the keyboard port never drives data. That read clears the keyboard latch unless a new edge arrives in the same cycle, and a new edge always wins. The bench scenarios cover the behaviour that depends on timing and configuration. They sweep every register value, and they visit each line in both modes to confirm the latency of two or three clock edges. They also cover acknowledge behaviour in each mode, the override of bit 4 in mouse mode, and a port read placed on the same cycle as a new edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int HI_LINES  = 8;
    localparam int MOUSE_IDX = 4;
    // Bits 0 (IRQ8) and 5 (IRQ13) are hard-wired to edge mode.
    localparam logic [HI_LINES-1:0] PROG_MASK = 8'hDE;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic mode_rd;
        logic mode_wr;
        logic kbd_rd;
    } io_hit_t;

    function automatic trig_mode_e line_mode(
        input logic [HI_LINES-1:0] modes,
        input int                  idx,
        input logic                mouse_on
    );
        if (idx == MOUSE_IDX && mouse_on) begin
            return TRIG_EDGE;
        end
        return (modes[idx] && PROG_MASK[idx]) ? TRIG_LEVEL : TRIG_EDGE;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/irqc_line.sv
module irqc_line
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_in,
    input  trig_mode_e mode,
    input  logic       clr,
    output logic       rise_o,
    output logic       irq_o
);
    logic prev_q;
    logic pend_q;

    assign rise_o = sync_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= sync_in;
            if (mode == TRIG_LEVEL) begin
                pend_q <= 1'b0;
            end else if (rise_o) begin
                pend_q <= 1'b1;
            end else if (clr) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign irq_o = (mode == TRIG_LEVEL) ? sync_in : pend_q;
endmodule

// File: rtl/irqc_mode_reg.sv
module irqc_mode_reg
    import irqc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h04D1,
    parameter logic [ADDR_W-1:0] KBD_ADDR  = 16'h0060
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [HI_LINES-1:0] io_wdata,
    input  logic                io_wr,
    input  logic                io_rd,
    output logic [HI_LINES-1:0] mode_q,
    output logic [HI_LINES-1:0] io_rdata,
    output logic                io_rdata_en,
    output logic                kbd_rd
);
    io_hit_t hit;

    always_comb begin
        hit.mode_rd = io_rd && (io_addr == MODE_ADDR);
        hit.mode_wr = io_wr && (io_addr == MODE_ADDR);
        hit.kbd_rd  = io_rd && (io_addr == KBD_ADDR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (hit.mode_wr) begin
            mode_q <= io_wdata & PROG_MASK;
        end
    end

    assign io_rdata_en = hit.mode_rd;
    assign io_rdata    = hit.mode_rd ? mode_q : '0;
    assign kbd_rd      = hit.kbd_rd;
endmodule

// File: rtl/irq_trigger_cond.sv
module irq_trigger_cond
    import irqc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h04D1,
    parameter logic [ADDR_W-1:0] KBD_ADDR  = 16'h0060
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [7:0]          io_wdata,
    input  logic                io_wr,
    input  logic                io_rd,
    output logic [7:0]          io_rdata,
    output logic                io_rdata_en,
    input  logic [7:0]          irq_hi_in,
    input  logic                kbd_irq_in,
    input  logic                mouse_en,
    input  logic [7:0]          irq_ack,
    output logic [7:0]          irq_hi_out,
    output logic                kbd_irq_out
);
    localparam int SYNC_W = HI_LINES + 1;

    logic [HI_LINES-1:0] mode_q;
    logic                kbd_rd;
    logic [SYNC_W-1:0]   sync_q;
    logic [HI_LINES-1:0] hi_sync;
    logic                kbd_sync;
    logic [HI_LINES-1:0] hi_rise;
    logic                kbd_rise;

    irqc_mode_reg #(
        .ADDR_W   (ADDR_W),
        .MODE_ADDR(MODE_ADDR),
        .KBD_ADDR (KBD_ADDR)
    ) u_mode_reg (
        .clk        (clk),
        .rst        (rst),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .mode_q     (mode_q),
        .io_rdata   (io_rdata),
        .io_rdata_en(io_rdata_en),
        .kbd_rd     (kbd_rd)
    );

    irqc_sync #(.W(SYNC_W)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({kbd_irq_in, irq_hi_in}),
        .q  (sync_q)
    );

    assign hi_sync  = sync_q[HI_LINES-1:0];
    assign kbd_sync = sync_q[HI_LINES];

    for (genvar i = 0; i < HI_LINES; i++) begin : g_line
        trig_mode_e mode_i;
        logic       clr_i;

        always_comb begin
            mode_i = line_mode(mode_q, i, mouse_en);
            if (i == MOUSE_IDX && mouse_en) begin
                clr_i = kbd_rd;
            end else begin
                clr_i = irq_ack[i];
            end
        end

        irqc_line u_line (
            .clk    (clk),
            .rst    (rst),
            .sync_in(hi_sync[i]),
            .mode   (mode_i),
            .clr    (clr_i),
            .rise_o (hi_rise[i]),
            .irq_o  (irq_hi_out[i])
        );
    end

    irqc_line u_kbd_line (
        .clk    (clk),
        .rst    (rst),
        .sync_in(kbd_sync),
        .mode   (TRIG_EDGE),
        .clr    (kbd_rd),
        .rise_o (kbd_rise),
        .irq_o  (kbd_irq_out)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] io_addr,
    input logic        io_rd,
    input logic [7:0]  io_rdata,
    input logic        io_rdata_en,
    input logic        mouse_en,
    input logic [7:0]  irq_ack,
    input logic [7:0]  irq_hi_out,
    input logic        kbd_irq_out,
    input logic [7:0]  mode_q,
    input logic [7:0]  hi_rise,
    input logic        kbd_rise
);
    logic rd_kbd;
    assign rd_kbd = io_rd && (io_addr == 16'h0060);

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == 8'h00));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        io_rdata_en |-> (io_rdata[0] == 1'b0 && io_rdata[5] == 1'b0));

    assert_irq8_edge_only_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_hi_out[0]) |-> $past(hi_rise[0]));

    assert_irq13_edge_only_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_hi_out[5]) |-> $past(hi_rise[5]));

    assert_edge_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_hi_out[0] && !irq_ack[0]) |=> irq_hi_out[0]);

    assert_kbd_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_kbd && !kbd_rise) |=> !kbd_irq_out);

    assert_mouse_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mouse_en && irq_hi_out[4] && !rd_kbd) |=> (irq_hi_out[4] || !mouse_en));

    assert_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
        rd_kbd |-> !io_rdata_en);

    assert_edge_wins_R10: assert property (@(posedge clk) disable iff (rst)
        kbd_rise |=> kbd_irq_out);
endmodule

bind irq_trigger_cond irqc_checker u_irqc_checker (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_rdata   (io_rdata),
    .io_rdata_en(io_rdata_en),
    .mouse_en   (mouse_en),
    .irq_ack    (irq_ack),
    .irq_hi_out (irq_hi_out),
    .kbd_irq_out(kbd_irq_out),
    .mode_q     (mode_q),
    .hi_rise    (hi_rise),
    .kbd_rise   (kbd_rise)
);

// File: tb/test_irq_trigger_cond.sv
module test_irq_trigger_cond;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        io_rdata_en;
    logic [7:0]  irq_hi_in = '0;
    logic        kbd_irq_in = 1'b0;
    logic        mouse_en = 1'b0;
    logic [7:0]  irq_ack = '0;
    logic [7:0]  irq_hi_out;
    logic        kbd_irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_trigger_cond i_irq_trigger_cond (
        .clk        (clk),
        .rst        (rst),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_rdata   (io_rdata),
        .io_rdata_en(io_rdata_en),
        .irq_hi_in  (irq_hi_in),
        .kbd_irq_in (kbd_irq_in),
        .mouse_en   (mouse_en),
        .irq_ack    (irq_ack),
        .irq_hi_out (irq_hi_out),
        .kbd_irq_out(kbd_irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        step(1);
        io_wr = 1'b0;
    endtask

    // Samples the combinational read path, then lets one clock edge pass.
    task automatic io_read(input logic [15:0] a, output logic en, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        #1;
        en = io_rdata_en; d = io_rdata;
        step(1);
        io_rd = 1'b0;
    endtask

    task automatic pulse_ack(input int i);
        irq_ack[i] = 1'b1;
        step(1);
        irq_ack[i] = 1'b0;
    endtask

    initial begin
        logic       en;
        logic [7:0] d;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        io_read(16'h04D1, en, d);
        chk("R1 reset read enable", en, 1);
        chk("R1 reset value", d, 8'h00);
        chk("R1 outputs idle", {kbd_irq_out, irq_hi_out}, 0);

        // R2/R3 exhaustive register sweep
        for (int v = 0; v < 256; v++) begin
            io_write(16'h04D1, v[7:0]);
            io_read(16'h04D1, en, d);
            chk("R2 readback enable", en, 1);
            chk("R2 R3 readback masked", d, v[7:0] & 8'hDE);
        end

        // R11 other addresses
        io_write(16'h04D1, 8'h00);
        io_write(16'h04D0, 8'hFF);
        io_write(16'h0060, 8'hFF);
        io_read(16'h04D0, en, d);
        chk("R11 no enable elsewhere", {en, d}, 9'h000);
        io_read(16'h04D1, en, d);
        chk("R11 register unchanged", d, 8'h00);

        // R2..R6 per-line sweep in both modes
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 2; m++) begin
                logic lvl;
                lvl = (m == 1) && (i != 0) && (i != 5);
                io_write(16'h04D1, 8'(m << i));
                step(2);
                irq_hi_in[i] = 1'b1;
                step(1);
                chk("R4 R6 no output after one edge", irq_hi_out[i], 0);
                step(1);
                chk("R6 level after two edges", irq_hi_out[i], lvl);
                step(1);
                chk("R4 asserted after three edges", irq_hi_out[i], 1);
                chk("R2 other lines quiet", irq_hi_out & ~(8'(1) << i), 0);
                if (lvl) begin
                    pulse_ack(i);
                    chk("R5 ack ignored in level", irq_hi_out[i], 1);
                end
                irq_hi_in[i] = 1'b0;
                step(3);
                chk("R4 R6 after input falls", irq_hi_out[i], !lvl);
                pulse_ack(i);
                chk("R5 cleared by ack", irq_hi_out[i], 0);
            end
        end
        io_write(16'h04D1, 8'h00);

        // R7/R9 keyboard latch
        kbd_irq_in = 1'b1;
        step(3);
        chk("R7 kbd latched", kbd_irq_out, 1);
        kbd_irq_in = 1'b0;
        step(3);
        chk("R7 kbd held", kbd_irq_out, 1);
        irq_ack = 8'hFF;
        step(1);
        irq_ack = 8'h00;
        chk("R7 ack does not clear kbd", kbd_irq_out, 1);
        io_write(16'h0060, 8'h5A);
        chk("R9 write to port keeps latch", kbd_irq_out, 1);
        io_read(16'h0060, en, d);
        chk("R9 no data driven", {en, d}, 9'h000);
        chk("R7 kbd cleared by read", kbd_irq_out, 0);

        // R10 same-cycle edge wins
        kbd_irq_in = 1'b1;
        step(2);
        io_read(16'h0060, en, d);
        chk("R10 new edge wins over read", kbd_irq_out, 1);
        kbd_irq_in = 1'b0;
        step(2);
        io_read(16'h0060, en, d);
        chk("R10 later read clears", kbd_irq_out, 0);

        // R8 mouse mode on IRQ12
        io_write(16'h04D1, 8'h10);
        mouse_en = 1'b1;
        step(1);
        irq_hi_in[4] = 1'b1;
        step(3);
        chk("R8 mouse latched", irq_hi_out[4], 1);
        irq_hi_in[4] = 1'b0;
        step(3);
        chk("R8 mouse edge despite level bit", irq_hi_out[4], 1);
        pulse_ack(4);
        chk("R8 ack ignored in mouse mode", irq_hi_out[4], 1);
        io_read(16'h0060, en, d);
        chk("R8 read clears mouse", irq_hi_out[4], 0);
        irq_hi_in[4] = 1'b1;
        step(2);
        io_read(16'h0060, en, d);
        chk("R10 mouse new edge wins", irq_hi_out[4], 1);
        irq_hi_in[4] = 1'b0;
        io_read(16'h0060, en, d);
        chk("R8 second read clears", irq_hi_out[4], 0);
        mouse_en = 1'b0;
        irq_hi_in[4] = 1'b1;
        step(2);
        chk("R8 level restored without mouse", irq_hi_out[4], 1);
        irq_hi_in[4] = 1'b0;
        step(2);
        chk("R8 level follows input", irq_hi_out[4], 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule